// File: doc/BRIEF.md
# Hardware Loop Setup Unit

This unit lets a small in-order processor run a loop body without branch overhead. When a loop-setup instruction is decoded, the unit works out the loop start address, end address and iteration count from the instruction's program counter, its immediate fields or the rs1 operand. It writes them into one set of loop registers. A 3-bit function field picks one of six setup operations, and each operation writes its own subset of the three registers. A global write-suppress input, raised for instance while the pipeline flushes or stalls, masks every write while leaving the decode results visible.

On the fetch side, the unit compares the fetch address with the stored end address. When the fetch reaches the loop end and more than one iteration is left, it asks fetch to jump back to the loop start and counts one iteration down. The last pass falls through with no redirect. A setup write to the count in the same cycle overrides that decrement.

Top module: `hwloop_unit`

## Requirements
- R1: After reset the start, end and count registers all read zero and no redirect is raised.
- R2: Function field instr[14:12] = 000 sets the start register to pc + sign-extended instr[31:20]; the write-enable vector (bit 0 start, bit 1 end, bit 2 count) reads 001 and the other registers keep their values.
- R3: Field 001 sets the end register to pc + sign-extended instr[31:20]; the enable vector reads 010.
- R4: Field 010 loads the count from rs1, the enable vector reads 100, and the rs1-used flag is high; rs1-used is high only for fields 010 and 100.
- R5: Field 011 loads the count from zero-extended instr[31:20]; the enable vector reads 100.
- R6: Field 100 writes all three registers (enable 111): count from rs1, start = pc + 4, end = pc + sign-extended instr[31:20].
- R7: Field 101 writes all three registers (enable 111): count from zero-extended instr[31:20], start = pc + 4, end = pc + (zero-extended instr[19:15] shifted left by one).
- R8: Fields 110 and 111 raise the illegal flag, leave the enable vector at 000 and change no register.
- R9: While the write-suppress input is high the enable vector is 000 and no register is written by decode, whatever the field.
- R10: With the instruction-valid input low the enable vector, illegal flag and rs1-used flag are all low.
- R11: When fetch is valid, the fetch PC equals the end register and the count is above one, the redirect output is high in that cycle with the start register as target, and the count is one lower on the next cycle.
- R12: When the loop end is reached with count one, the count drops to zero without a redirect; with count zero nothing happens.
- R13: A count write from decode in the same cycle as a loop-end decrement wins; start or end writes in that cycle do not block the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Decode slot holds a loop-setup instruction |
| instr_i | input | 32 | Instruction word |
| pc_i | input | ADDR_W | Address of the decoded instruction |
| rs1_i | input | CNT_W | Value of the rs1 operand |
| wr_suppress_i | input | 1 | Masks all loop-register writes |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| fetch_pc_i | input | ADDR_W | Current fetch address |
| wr_en_o | output | 3 | Write enables: bit 0 start, bit 1 end, bit 2 count |
| rs1_used_o | output | 1 | Operation reads rs1 (for hazard stalls) |
| illegal_o | output | 1 | Reserved function field decoded |
| redirect_o | output | 1 | Fetch must jump to the loop start |
| redirect_pc_o | output | ADDR_W | Redirect target |
| start_o | output | ADDR_W | Loop start register |
| end_o | output | ADDR_W | Loop end register |
| count_o | output | CNT_W | Remaining iteration count |

## Verification
Each of the eight function-field values is decoded with positive and negative immediates, valid and invalid slots, and suppress both high and low. This separates operand selection errors (start from pc+4 against pc+offset, count from rs1 against immediate, sign against zero extension) from write-mask errors. A full loop is run with fetch walking up to the end address, covering multi-pass redirects, the silent last pass and the idle zero count. Count writes that collide with a loop-end hit show whether the setup write has priority. A long randomized stretch steers fetch onto the end address often, so that decode and loop-end activity overlap in many combinations.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    // setup operations selected by the 3-bit function field
    typedef enum logic [2:0] {
        OP_SET_START = 3'b000,
        OP_SET_END   = 3'b001,
        OP_CNT_REG   = 3'b010,
        OP_CNT_IMM   = 3'b011,
        OP_SETUP_REG = 3'b100,
        OP_SETUP_IMM = 3'b101,
        OP_RSV_6     = 3'b110,
        OP_RSV_7     = 3'b111
    } hwl_op_e;

    // write-enable vector layout
    localparam int unsigned WE_START = 0;
    localparam int unsigned WE_END   = 1;
    localparam int unsigned WE_CNT   = 2;
    localparam int unsigned WE_W     = 3;

    // instruction field positions
    localparam int unsigned FUNC_HI = 14;
    localparam int unsigned FUNC_LO = 12;
    localparam int unsigned IMM_HI  = 31;
    localparam int unsigned IMM_LO  = 20;
    localparam int unsigned SIMM_HI = 19;
    localparam int unsigned SIMM_LO = 15;

endpackage

// File: rtl/hwloop_decode.sv
module hwloop_decode
    import hwloop_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned INSTR_W    = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic               instr_valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [CNT_W-1:0]   rs1_i,
    input  logic               wr_suppress_i,
    output logic [WE_W-1:0]    wr_en_o,
    output logic [ADDR_W-1:0]  start_val_o,
    output logic [ADDR_W-1:0]  end_val_o,
    output logic [CNT_W-1:0]   cnt_val_o,
    output logic               rs1_used_o,
    output logic               illegal_o
);

    localparam int unsigned IMM_W  = IMM_HI - IMM_LO + 1;
    localparam int unsigned SIMM_W = SIMM_HI - SIMM_LO + 1;

    typedef struct packed {
        logic [WE_W-1:0]   we;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] stop;
        logic [CNT_W-1:0]  cnt;
        logic              rs1_used;
        logic              illegal;
    } dec_t;

    dec_t              dec_d;
    hwl_op_e           op;
    logic [WE_W-1:0]   we_raw;
    logic [ADDR_W-1:0] imm_sext;
    logic [ADDR_W-1:0] imm_short;
    logic [CNT_W-1:0]  imm_zext;
    logic [ADDR_W-1:0] pc_rel;
    logic [ADDR_W-1:0] pc_next;
    logic [ADDR_W-1:0] pc_short;
    logic              unused_low_bits;

    assign unused_low_bits = ^instr_i[FUNC_LO-1:0];

    always_comb begin
        op        = hwl_op_e'(instr_i[FUNC_HI:FUNC_LO]);
        imm_sext  = {{(ADDR_W-IMM_W){instr_i[IMM_HI]}}, instr_i[IMM_HI:IMM_LO]};
        imm_zext  = {{(CNT_W-IMM_W){1'b0}}, instr_i[IMM_HI:IMM_LO]};
        imm_short = {{(ADDR_W-SIMM_W-1){1'b0}}, instr_i[SIMM_HI:SIMM_LO], 1'b0};
        pc_rel    = pc_i + imm_sext;
        pc_next   = pc_i + ADDR_W'(INSN_BYTES);
        pc_short  = pc_i + imm_short;

        we_raw         = '0;
        dec_d.start    = pc_next;
        dec_d.stop     = pc_rel;
        dec_d.cnt      = imm_zext;
        dec_d.rs1_used = 1'b0;
        dec_d.illegal  = 1'b0;

        if (instr_valid_i) begin
            unique case (op)
                OP_SET_START: begin
                    we_raw[WE_START] = 1'b1;
                    dec_d.start      = pc_rel;
                end
                OP_SET_END: begin
                    we_raw[WE_END] = 1'b1;
                end
                OP_CNT_REG: begin
                    we_raw[WE_CNT] = 1'b1;
                    dec_d.cnt      = rs1_i;
                    dec_d.rs1_used = 1'b1;
                end
                OP_CNT_IMM: begin
                    we_raw[WE_CNT] = 1'b1;
                end
                OP_SETUP_REG: begin
                    we_raw         = '1;
                    dec_d.cnt      = rs1_i;
                    dec_d.rs1_used = 1'b1;
                end
                OP_SETUP_IMM: begin
                    we_raw     = '1;
                    dec_d.stop = pc_short;
                end
                OP_RSV_6, OP_RSV_7: begin
                    dec_d.illegal = 1'b1;
                end
                default: ;
            endcase
        end

        // global suppress wins over every decoded write
        dec_d.we = wr_suppress_i ? '0 : we_raw;
    end

    assign wr_en_o     = dec_d.we;
    assign start_val_o = dec_d.start;
    assign end_val_o   = dec_d.stop;
    assign cnt_val_o   = dec_d.cnt;
    assign rs1_used_o  = dec_d.rs1_used;
    assign illegal_o   = dec_d.illegal;

endmodule

// File: rtl/hwloop_state.sv
module hwloop_state
    import hwloop_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WE_W-1:0]   wr_en_i,
    input  logic [ADDR_W-1:0] start_val_i,
    input  logic [ADDR_W-1:0] end_val_i,
    input  logic [CNT_W-1:0]  cnt_val_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_pc_o,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] end_o,
    output logic [CNT_W-1:0]  count_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] stop;
        logic [CNT_W-1:0]  cnt;
    } loop_st_t;

    loop_st_t st_d;
    loop_st_t st_q;
    logic     end_hit;
    logic     take_branch;

    always_comb begin
        st_d        = st_q;
        end_hit     = fetch_valid_i && (fetch_pc_i == st_q.stop) && (st_q.cnt != '0);
        take_branch = end_hit && (st_q.cnt > CNT_W'(1));

        if (wr_en_i[WE_START]) st_d.start = start_val_i;
        if (wr_en_i[WE_END])   st_d.stop  = end_val_i;

        // a setup write of the count overrides the loop-end decrement
        if (wr_en_i[WE_CNT]) begin
            st_d.cnt = cnt_val_i;
        end else if (end_hit) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o    = take_branch;
    assign redirect_pc_o = st_q.start;
    assign start_o       = st_q.start;
    assign end_o         = st_q.stop;
    assign count_o       = st_q.cnt;

    // R11
    property p_taken_decrements;
        @(posedge clk_i) disable iff (!rst_ni)
            (redirect_o && !wr_en_i[WE_CNT]) |=> (count_o == $past(count_o) - CNT_W'(1));
    endproperty
    taken_decrements_chk: assert property (p_taken_decrements);

    // R12
    property p_idle_count_quiet;
        @(posedge clk_i) disable iff (!rst_ni)
            (count_o == '0 && !wr_en_i[WE_CNT]) |-> (!redirect_o ##1 count_o == '0);
    endproperty
    idle_count_quiet_chk: assert property (p_idle_count_quiet);

    // R13
    property p_cnt_write_wins;
        @(posedge clk_i) disable iff (!rst_ni)
            wr_en_i[WE_CNT] |=> (count_o == $past(cnt_val_i));
    endproperty
    cnt_write_wins_chk: assert property (p_cnt_write_wins);

    // R9
    property p_start_holds;
        @(posedge clk_i) disable iff (!rst_ni)
            !wr_en_i[WE_START] |=> $stable(start_o);
    endproperty
    start_holds_chk: assert property (p_start_holds);

    // R9
    property p_end_holds;
        @(posedge clk_i) disable iff (!rst_ni)
            !wr_en_i[WE_END] |=> $stable(end_o);
    endproperty
    end_holds_chk: assert property (p_end_holds);

endmodule

// File: rtl/hwloop_unit.sv
module hwloop_unit
    import hwloop_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              instr_valid_i,
    input  logic [31:0]       instr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [CNT_W-1:0]  rs1_i,
    input  logic              wr_suppress_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    output logic [2:0]        wr_en_o,
    output logic              rs1_used_o,
    output logic              illegal_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_pc_o,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] end_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [WE_W-1:0]   dec_we;
    logic [ADDR_W-1:0] dec_start;
    logic [ADDR_W-1:0] dec_end;
    logic [CNT_W-1:0]  dec_cnt;

    hwloop_decode #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .INSTR_W    (32),
        .INSN_BYTES (INSN_BYTES)
    ) u_decode (
        .instr_valid_i (instr_valid_i),
        .instr_i       (instr_i),
        .pc_i          (pc_i),
        .rs1_i         (rs1_i),
        .wr_suppress_i (wr_suppress_i),
        .wr_en_o       (dec_we),
        .start_val_o   (dec_start),
        .end_val_o     (dec_end),
        .cnt_val_o     (dec_cnt),
        .rs1_used_o    (rs1_used_o),
        .illegal_o     (illegal_o)
    );

    hwloop_state #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_state (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (dec_we),
        .start_val_i   (dec_start),
        .end_val_i     (dec_end),
        .cnt_val_i     (dec_cnt),
        .fetch_valid_i (fetch_valid_i),
        .fetch_pc_i    (fetch_pc_i),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .start_o       (start_o),
        .end_o         (end_o),
        .count_o       (count_o)
    );

    assign wr_en_o = dec_we;

    // R9
    property p_suppress_masks;
        @(posedge clk_i) disable iff (!rst_ni)
            wr_suppress_i |-> (wr_en_o == '0);
    endproperty
    suppress_masks_chk: assert property (p_suppress_masks);

    // R8
    property p_illegal_no_write;
        @(posedge clk_i) disable iff (!rst_ni)
            illegal_o |-> (wr_en_o == '0);
    endproperty
    illegal_no_write_chk: assert property (p_illegal_no_write);

    // R2
    property p_we_shape;
        @(posedge clk_i) disable iff (!rst_ni)
            ($countones(wr_en_o) != 2);
    endproperty
    we_shape_chk: assert property (p_we_shape);

    // R10
    property p_idle_slot_quiet;
        @(posedge clk_i) disable iff (!rst_ni)
            !instr_valid_i |-> (wr_en_o == '0 && !rs1_used_o && !illegal_o);
    endproperty
    idle_slot_quiet_chk: assert property (p_idle_slot_quiet);

endmodule

// File: tb/hwloop_unit_test.sv
module hwloop_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] rs1_i = '0;
    logic        wr_suppress_i = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic [2:0]  wr_en_o;
    logic        rs1_used_o;
    logic        illegal_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic [31:0] start_o;
    logic [31:0] end_o;
    logic [31:0] count_o;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    logic [31:0] m_start = '0;
    logic [31:0] m_end   = '0;
    logic [31:0] m_cnt   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwloop_unit uut (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .instr_valid_i (instr_valid_i),
        .instr_i       (instr_i),
        .pc_i          (pc_i),
        .rs1_i         (rs1_i),
        .wr_suppress_i (wr_suppress_i),
        .fetch_valid_i (fetch_valid_i),
        .fetch_pc_i    (fetch_pc_i),
        .wr_en_o       (wr_en_o),
        .rs1_used_o    (rs1_used_o),
        .illegal_o     (illegal_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .start_o       (start_o),
        .end_o         (end_o),
        .count_o       (count_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [11:0] imm, input logic [4:0] s5,
                                       input logic [2:0] code);
        return {imm, s5, code, 12'h0b5};
    endfunction

    task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                        input logic [31:0] rs1, input logic sup,
                        input logic fv, input logic [31:0] fpc);
        int          code;
        logic [31:0] simm, zimm, shim, ns, ne, nc, cv;
        logic [2:0]  e_we;
        logic        e_ill, e_used, hit, e_redir;
        string       t, tc;
        instr_valid_i = v; instr_i = ins; pc_i = pc; rs1_i = rs1;
        wr_suppress_i = sup; fetch_valid_i = fv; fetch_pc_i = fpc;
        #1;
        code = int'(ins[14:12]);
        simm = {{20{ins[31]}}, ins[31:20]};
        zimm = {20'd0, ins[31:20]};
        shim = {26'd0, ins[19:15], 1'b0};
        e_we = 3'b000; e_ill = 1'b0; e_used = 1'b0;
        if (v) begin
            case (code)
                0: e_we = 3'b001;
                1: e_we = 3'b010;
                2: begin e_we = 3'b100; e_used = 1'b1; end
                3: e_we = 3'b100;
                4: begin e_we = 3'b111; e_used = 1'b1; end
                5: e_we = 3'b111;
                default: e_ill = 1'b1;
            endcase
        end
        if (sup) e_we = 3'b000;
        if (!v)       t = "R10";
        else if (sup) t = "R9";
        else case (code)
            0: t = "R2"; 1: t = "R3"; 2: t = "R4";
            3: t = "R5"; 4: t = "R6"; 5: t = "R7";
            default: t = "R8";
        endcase
        ns = m_start; ne = m_end; nc = m_cnt;
        if (e_we[0]) ns = (code == 0) ? pc + simm : pc + 32'd4;
        if (e_we[1]) ne = (code == 5) ? pc + shim : pc + simm;
        cv = (code == 2 || code == 4) ? rs1 : zimm;
        hit = fv && (fpc == m_end) && (m_cnt != 0);
        e_redir = hit && (m_cnt > 1);
        if (e_we[2]) nc = cv;
        else if (hit) nc = m_cnt - 1;
        if (hit && e_we[2])  tc = "R13";
        else if (e_redir)    tc = "R11";
        else if (hit)        tc = "R12";
        else                 tc = t;

        chk(t, "wr_en", {29'd0, wr_en_o}, {29'd0, e_we});
        chk(t, "illegal", {31'd0, illegal_o}, {31'd0, e_ill});
        chk(t, "rs1_used", {31'd0, rs1_used_o}, {31'd0, e_used});
        chk(hit ? (e_redir ? "R11" : "R12") : "R12", "redirect",
            {31'd0, redirect_o}, {31'd0, e_redir});
        if (e_redir) chk("R11", "redirect_pc", redirect_pc_o, m_start);

        @(posedge clk);
        m_start = ns; m_end = ne; m_cnt = nc;
        @(negedge clk);
        chk(t, "start", start_o, m_start);
        chk(t, "end", end_o, m_end);
        chk(tc, "count", count_o, m_cnt);
    endtask

    task automatic idle();
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "start", start_o, 32'd0);
        chk("R1", "end", end_o, 32'd0);
        chk("R1", "count", count_o, 32'd0);
        chk("R1", "redirect", {31'd0, redirect_o}, 32'd0);

        // each operation, positive and negative offsets
        step(1'b1, mk(12'h010, 5'd3, 3'b000), 32'h200, 32'd9, 1'b0, 1'b0, 0); // R2
        step(1'b1, mk(12'hff0, 5'd3, 3'b000), 32'h200, 32'd9, 1'b0, 1'b0, 0); // R2 negative
        step(1'b1, mk(12'h040, 5'd1, 3'b001), 32'h300, 32'd9, 1'b0, 1'b0, 0); // R3
        step(1'b1, mk(12'hffc, 5'd1, 3'b001), 32'h300, 32'd9, 1'b0, 1'b0, 0); // R3 negative
        step(1'b1, mk(12'h123, 5'd2, 3'b010), 32'h300, 32'd77, 1'b0, 1'b0, 0); // R4
        step(1'b1, mk(12'hfff, 5'd2, 3'b011), 32'h300, 32'd77, 1'b0, 1'b0, 0); // R5 zext
        step(1'b1, mk(12'h020, 5'd0, 3'b100), 32'h100, 32'd3, 1'b0, 1'b0, 0); // R6
        step(1'b1, mk(12'h005, 5'd9, 3'b101), 32'h400, 32'd3, 1'b0, 1'b0, 0); // R7
        step(1'b1, mk(12'h005, 5'd9, 3'b110), 32'h500, 32'd3, 1'b0, 1'b0, 0); // R8
        step(1'b1, mk(12'h005, 5'd9, 3'b111), 32'h500, 32'd3, 1'b0, 1'b0, 0); // R8
        for (int c = 0; c < 8; c++)                                            // R9
            step(1'b1, mk(12'h777, 5'd5, 3'(c)), 32'h600, 32'd55, 1'b1, 1'b0, 0);
        for (int c = 0; c < 8; c++)                                            // R10
            step(1'b0, mk(12'h777, 5'd5, 3'(c)), 32'h600, 32'd55, 1'b0, 1'b0, 0);

        // full loop: R6 setup, then R11 twice, R12 last pass and idle end
        step(1'b1, mk(12'h020, 5'd0, 3'b100), 32'h100, 32'd3, 1'b0, 1'b0, 0);
        for (int pass = 0; pass < 4; pass++) begin
            for (int a = 32'h104; a <= 32'h120; a += 4)
                step(1'b0, 32'd0, 32'd0, 32'd0, 1'b0, 1'b1, 32'(a));
        end
        // fetch stalled at the end address: no repeat decrement while invalid
        step(1'b0, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h120);

        // R13: count write collides with loop end
        step(1'b1, mk(12'h004, 5'd0, 3'b011), 32'h100, 32'd0, 1'b0, 1'b0, 0);
        step(1'b1, mk(12'h009, 5'd0, 3'b011), 32'h100, 32'd0, 1'b0, 1'b1, 32'h120);
        // R13: start-only write does not block the decrement
        step(1'b1, mk(12'h008, 5'd0, 3'b000), 32'h100, 32'd0, 1'b0, 1'b1, 32'h120);
        // suppressed count write: decrement goes ahead (R9 with R11)
        step(1'b1, mk(12'h001, 5'd0, 3'b011), 32'h100, 32'd0, 1'b1, 1'b1, 32'h120);

        // randomized stretch with frequent loop-end hits
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r1, r2, r3, fpc;
            r1 = $urandom(); r2 = $urandom(); r3 = $urandom();
            fpc = (r3[1:0] != 2'b00) ? m_end : {20'd0, r3[15:4], 2'b00};
            step(r1[0] & r1[1], {r2[31:20], r2[19:15], r1[14:12], 12'h0b5},
                 {16'd0, r2[15:0]} & 32'hfffc, {29'd0, r1[7:5]},
                 (r1[9:8] == 2'b11), r1[10] | r1[11], fpc);
        end
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule